// File: doc/BRIEF.md
# Misaligned Word Load Combiner

This block sits between a load requester and a memory port that can only move whole 32-bit words at word-aligned addresses. The requester gives a byte address and an access size of byte, halfword or word. The block turns that request into one aligned word read. When the wanted bytes straddle two memory words, it issues two aligned reads in sequence instead. It then selects the wanted bytes from the returned word or words and delivers them right-justified and zero-extended on a single-cycle result strobe.

A strict-alignment input switches the block into a checking mode. In that mode, any access whose byte address is not a multiple of its size returns a fault at once and touches no memory. Accesses that are naturally aligned proceed as usual. Memory reads use a request/ready handshake followed by a response-valid strobe that carries the read data. While a sequence is in flight, `busy` is high and new requests are ignored.

The sequencer steps through the states IDLE, RD_LO (first word requested), WT_LO (waiting for first data), RD_HI (second word requested), WT_HI (waiting for second data) and DONE (result presented). It takes these transitions:
- IDLE→RD_LO: a non-faulting request is accepted.
- IDLE→DONE: a faulting request is accepted.
- RD_LO→WT_LO and RD_HI→WT_HI: the memory ready handshake completes.
- WT_LO→RD_HI: first data arrives and the access crosses a word boundary.
- WT_LO→DONE: first data arrives and the access fits in one word.
- WT_HI→DONE: second data arrives.
- DONE→IDLE: unconditionally.

Top module: `misaligned_load_joiner`

## Requirements
- R1: Every memory read address is a word address, with bits [1:0] equal to zero. The first read goes to the request's byte address with its two low bits cleared.
- R2: A byte access (size code 2'b00) is served at any byte address, odd ones included, with exactly one memory read.
- R3: A halfword access (size code 2'b01) uses one read, except when address bits [1:0] equal 3. In that case it uses two reads.
- R4: A word access (size code 2'b10) uses one read when address bits [1:0] are 0 and two reads otherwise. In a two-read access, the lower word is read first. The second read goes to the lower word address plus 4, wrapping modulo 2^AW.
- R5: The result is little-endian and right-justified. Result bits [8i+7:8i] hold the memory byte at byte address addr+i, for each i below the access size. All result bits above the access size are zero.
- R6: `rsp_valid` is a one-cycle pulse. It is raised in the cycle after the clock edge that captures the last needed memory response.
- R7: With `strict_align` high, an access whose address is not a multiple of its size (1, 2 or 4 bytes) issues no memory read. It answers with `rsp_valid` and `rsp_fault` high in the cycle after acceptance, and `rsp_data` is zero.
- R8: With `strict_align` high, naturally aligned accesses complete normally with `rsp_fault` low. With `strict_align` low, `rsp_fault` is never raised.
- R9: A request is accepted only while `busy` is low. `busy` is high from the cycle after acceptance until the result cycle, inclusive. A request held during that time is neither served nor queued.
- R10: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is seen.
- R11: Size code 2'b11 behaves exactly like a word access.
- R12: Out of reset, `busy`, `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict_align | input | 1 | Fault on any access that is not naturally aligned |
| req_valid | input | 1 | Load request present |
| req_addr | input | AW | Byte address of the load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 or 11 word |
| busy | output | 1 | A request is being processed |
| mem_req_valid | output | 1 | Word read request |
| mem_req_addr | output | AW | Word-aligned read address |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | DW | Read data word |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Misalignment fault (strict mode) |
| rsp_data | output | DW | Right-justified, zero-extended result |

## Verification
A faulting request reports its result one cycle after acceptance. Every other request reports its result exactly one cycle after the edge that captured its last memory response. The bench drives and samples on falling edges and numbers each falling edge after acceptance. A fault must therefore appear on falling edge 0, and any other result on the falling edge right after the one where the last response was driven. Each memory handshake is recorded with its address, so the read count, the order and the wrap of the second word address are compared against values derived from the byte address and the size. Memory ready and response latencies vary across the sweep, so the timing rule is checked under several stall patterns.

// File: rtl/mlj_pkg.sv
package mlj_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORD2 = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_WT_LO,
        ST_RD_HI,
        ST_WT_HI,
        ST_DONE
    } ld_state_e;

endpackage

// File: rtl/mlj_classify.sv
module mlj_classify
    import mlj_pkg::*;
#(
    parameter int AW    = 16,
    parameter int BYTES = 4
) (
    input  logic [AW-1:0]              addr,
    input  logic [1:0]                 size,
    input  logic                       strict,
    output logic [$clog2(BYTES):0]     nbytes,
    output logic                       crosses,
    output logic                       fault,
    output logic [AW-1:0]              lo_addr,
    output logic [AW-1:0]              hi_addr
);
    localparam int OFFW = $clog2(BYTES);
    localparam int CW   = OFFW + 1;
    localparam int RW   = CW + 1;

    logic [OFFW-1:0] off;
    logic [CW-1:0]   nb;
    logic [RW-1:0]   reach;

    always_comb begin
        off = addr[OFFW-1:0];
        unique case (acc_size_e'(size))
            SZ_BYTE: nb = CW'(1);
            SZ_HALF: nb = CW'(2);
            default: nb = CW'(BYTES);
        endcase
        // last byte position reached by the access, relative to the lower word
        reach   = {1'b0, nb} + RW'(off);
        crosses = reach > RW'(BYTES);
        // natural alignment: offset has no bits below the size
        fault   = strict && ((CW'(off) & (nb - CW'(1))) != '0);
        lo_addr = {addr[AW-1:OFFW], {OFFW{1'b0}}};
        hi_addr = lo_addr + AW'(BYTES);
        nbytes  = nb;
    end

endmodule

// File: rtl/mlj_merge.sv
module mlj_merge #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]                 lo_word,
    input  logic [DW-1:0]                 hi_word,
    input  logic [$clog2(DW/8)-1:0]       off,
    input  logic [$clog2(DW/8):0]         nbytes,
    output logic [DW-1:0]                 data
);
    localparam int BYTES = DW / 8;
    localparam int OFFW  = $clog2(BYTES);

    logic [2*DW-1:0] joined;
    logic [2*DW-1:0] shifted;

    always_comb begin
        joined  = {hi_word, lo_word};
        shifted = joined >> {off, 3'b000};
    end

    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam logic [OFFW:0] LANE = (OFFW+1)'(i);
        assign data[8*i +: 8] = (nbytes > LANE) ? shifted[8*i +: 8] : 8'h00;
    end

endmodule

// File: rtl/mlj_ctrl.sv
module mlj_ctrl
    import mlj_pkg::*;
#(
    parameter int AW   = 16,
    parameter int OFFW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_fault,
    input  logic          req_cross,
    input  logic [AW-1:0] req_lo,
    input  logic [AW-1:0] req_hi,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    output logic          busy,
    output logic          take_req,
    output logic          load_lo,
    output logic          load_res,
    output logic          sel_second,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    output logic          rsp_valid
);
    ld_state_e     state, state_nx;
    logic          cross_q;
    logic [AW-1:0] lo_q;
    logic [AW-1:0] hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request attributes captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cross_q <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (take_req) begin
            cross_q <= req_cross;
            lo_q    <= req_lo;
            hi_q    <= req_hi;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid)     state_nx = req_fault ? ST_DONE : ST_RD_LO;
            ST_RD_LO: if (mem_req_ready) state_nx = ST_WT_LO;
            ST_WT_LO: if (mem_rsp_valid) state_nx = cross_q ? ST_RD_HI : ST_DONE;
            ST_RD_HI: if (mem_req_ready) state_nx = ST_WT_HI;
            ST_WT_HI: if (mem_rsp_valid) state_nx = ST_DONE;
            ST_DONE:                     state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy          = (state != ST_IDLE);
        take_req      = (state == ST_IDLE) && req_valid;
        load_lo       = (state == ST_WT_LO) && mem_rsp_valid && cross_q;
        load_res      = ((state == ST_WT_LO) && mem_rsp_valid && !cross_q)
                      || ((state == ST_WT_HI) && mem_rsp_valid);
        sel_second    = (state == ST_WT_HI);
        mem_req_valid = (state == ST_RD_LO) || (state == ST_RD_HI);
        mem_req_addr  = (state == ST_RD_HI) ? hi_q : lo_q;
        rsp_valid     = (state == ST_DONE);
    end

    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFFW-1:0] == '0));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_fault_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && req_fault) |=> (rsp_valid && !mem_req_valid));

    a_r9_read_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

endmodule

// File: rtl/misaligned_load_joiner.sv
module misaligned_load_joiner
    import mlj_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_align,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_size,
    output logic          busy,
    output logic          mem_req_valid,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_req_ready,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [DW-1:0] rsp_data
);
    localparam int BYTES = DW / 8;
    localparam int OFFW  = $clog2(BYTES);

    logic [OFFW:0]   cl_nbytes;
    logic            cl_cross;
    logic            cl_fault;
    logic [AW-1:0]   cl_lo;
    logic [AW-1:0]   cl_hi;

    logic            take_req, load_lo, load_res, sel_second;

    logic [OFFW-1:0] off_q;
    logic [OFFW:0]   nb_q;
    logic            fault_q;
    logic [DW-1:0]   lo_word_q;
    logic [DW-1:0]   res_q;
    logic [DW-1:0]   merged;
    logic [DW-1:0]   mg_lo;

    mlj_classify #(.AW(AW), .BYTES(BYTES)) u_class (
        .addr    (req_addr),
        .size    (req_size),
        .strict  (strict_align),
        .nbytes  (cl_nbytes),
        .crosses (cl_cross),
        .fault   (cl_fault),
        .lo_addr (cl_lo),
        .hi_addr (cl_hi)
    );

    mlj_ctrl #(.AW(AW), .OFFW(OFFW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_fault     (cl_fault),
        .req_cross     (cl_cross),
        .req_lo        (cl_lo),
        .req_hi        (cl_hi),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .busy          (busy),
        .take_req      (take_req),
        .load_lo       (load_lo),
        .load_res      (load_res),
        .sel_second    (sel_second),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .rsp_valid     (rsp_valid)
    );

    // on the second response the lower word comes from the holding register
    assign mg_lo = sel_second ? lo_word_q : mem_rsp_data;

    mlj_merge #(.DW(DW)) u_merge (
        .lo_word (mg_lo),
        .hi_word (mem_rsp_data),
        .off     (off_q),
        .nbytes  (nb_q),
        .data    (merged)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q     <= '0;
            nb_q      <= '0;
            fault_q   <= 1'b0;
            lo_word_q <= '0;
            res_q     <= '0;
        end else begin
            if (take_req) begin
                off_q   <= req_addr[OFFW-1:0];
                nb_q    <= cl_nbytes;
                fault_q <= cl_fault;
                if (cl_fault) res_q <= '0;
            end
            if (load_lo)  lo_word_q <= mem_rsp_data;
            if (load_res) res_q     <= merged;
        end
    end

    assign rsp_fault = rsp_valid && fault_q;
    assign rsp_data  = res_q;

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault && nb_q == (OFFW+1)'(1)) |-> (rsp_data[DW-1:8] == '0));

    a_r7_fault_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_data == '0));

    a_r7_fault_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && fault_q) |-> !mem_req_valid);

    a_r8_lenient_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (take_req && !strict_align) |=> !fault_q);

endmodule

// File: tb/sim_misaligned_load_joiner.sv
module sim_misaligned_load_joiner;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strict_align = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = '0;
    logic          busy;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_ready = 1'b0;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          rsp_valid;
    logic          rsp_fault;
    logic [DW-1:0] rsp_data;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    misaligned_load_joiner #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .strict_align(strict_align),
        .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
        .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        logic [7:0] t;
        t = a[7:0] * 8'd29;
        return t ^ a[15:8] ^ 8'h5B;
    endfunction

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] wa);
        logic [DW-1:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = mem_byte(wa + AW'(i));
        return w;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_load(input logic [AW-1:0] a, input logic [1:0] sz, input bit strict,
                            input int lat, input int rdel, input bit intrude);
        int nb, off, exp_reads, nreads, waitc, pcnt, resp_it, it;
        bit exp_fault, pend, done;
        logic [31:0] exp_data;
        logic [AW-1:0] rd_addr [2];
        logic [AW-1:0] lo_wa;
        nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        off = int'(a[1:0]);
        exp_fault = strict && ((off % nb) != 0);
        exp_reads = exp_fault ? 0 : ((off + nb > 4) ? 2 : 1);
        exp_data = '0;
        if (!exp_fault)
            for (int i = 0; i < nb; i++) exp_data[8*i +: 8] = mem_byte(a + AW'(i));
        lo_wa = {a[AW-1:2], 2'b00};
        nreads = 0; waitc = 0; pcnt = 0; pend = 0; resp_it = -10; done = 0;
        rd_addr[0] = '0; rd_addr[1] = '0;

        @(negedge clk);
        chk(busy == 1'b0, "R9 idle before request", 32'(busy), 0);
        strict_align = strict; req_addr = a; req_size = sz; req_valid = 1'b1;
        it = 0;
        while (!done && it < 80) begin
            @(negedge clk);
            mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
            if (intrude) begin
                req_addr = a ^ 16'h0041; req_size = 2'd2;
            end else begin
                req_valid = 1'b0;
            end
            if (it == 0) chk(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
            if (rsp_valid) begin
                done = 1;
                req_valid = 1'b0;
                chk(rsp_fault == exp_fault, exp_fault ? "R7 fault raised" : "R8 no fault",
                    32'(rsp_fault), 32'(exp_fault));
                chk(rsp_data == exp_data, "R5 merged data", rsp_data, exp_data);
                chk(nreads == exp_reads, (sz == 2'd0) ? "R2 read count" :
                    (sz == 2'd1) ? "R3 read count" : (sz == 2'd3) ? "R11 read count" : "R4 read count",
                    32'(nreads), 32'(exp_reads));
                if (exp_fault)
                    chk(it == 0, "R7 fault timing", 32'(it), 0);
                else
                    chk(it == resp_it + 1, "R6 result timing", 32'(it), 32'(resp_it + 1));
                if (exp_reads >= 1)
                    chk(rd_addr[0] == lo_wa, "R1 first word address", 32'(rd_addr[0]), 32'(lo_wa));
                if (exp_reads == 2)
                    chk(rd_addr[1] == lo_wa + AW'(4), "R4 second word address",
                        32'(rd_addr[1]), 32'(lo_wa + AW'(4)));
            end else begin
                if (pend) begin
                    if (pcnt == 0) begin
                        mem_rsp_valid = 1'b1;
                        mem_rsp_data = mem_word(rd_addr[nreads-1]);
                        resp_it = it;
                        pend = 0;
                    end else pcnt--;
                end
                if (mem_req_valid) begin
                    if (waitc >= lat) begin
                        mem_req_ready = 1'b1;
                        if (nreads < 2) rd_addr[nreads] = mem_req_addr;
                        nreads++;
                        pend = 1; pcnt = rdel; waitc = 0;
                    end else waitc++;
                end
            end
            it++;
        end
        if (!done) chk(1'b0, "R6 no result", 32'(it), 0);
        if (intrude) begin
            @(negedge clk);
            chk(busy == 1'b0 && mem_req_valid == 1'b0, "R9 held request ignored",
                32'({busy, mem_req_valid}), 0);
        end
    endtask

    initial begin
        logic [AW-1:0] addrs [12];
        for (int i = 0; i < 8; i++) addrs[i] = AW'(i);
        for (int i = 0; i < 4; i++) addrs[8+i] = AW'(16'hFFFC + i);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R12 reset state",
            32'({busy, rsp_valid, mem_req_valid}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R12 after release",
            32'({busy, rsp_valid, mem_req_valid}), 0);
        for (int m = 0; m < 2; m++)
            for (int ai = 0; ai < 12; ai++)
                for (int s = 0; s < 4; s++)
                    run_load(addrs[ai], 2'(s), m[0], (ai + s) % 3, (ai * 2 + s + m) % 3, 1'b0);
        // held request during two-read and fault sequences
        run_load(16'h0013, 2'd2, 1'b0, 2, 1, 1'b1);
        run_load(16'h0203, 2'd1, 1'b0, 0, 2, 1'b1);
        run_load(16'h0021, 2'd2, 1'b1, 0, 0, 1'b1);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 150000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule